// File: doc/BRIEF.md
# Chained Transfer Descriptor Sequencer

This block steers one DMA channel through a chain of transfer descriptors held in memory. Software first programs the source, destination, next-pointer and control registers with the values of the first descriptor. It then sets the enable bit in a separate configuration register. The block starts the data mover for that descriptor and waits for the mover to report completion. If the next-pointer is not null, the block reads the next four-word descriptor over a simple word-read port. It then replaces all four descriptor registers together and starts the mover again. This continues until a descriptor with a null next-pointer has finished.

A per-descriptor terminal-count pulse is raised when the control word asks for it. An error pulse is raised when either the mover or a descriptor read reports a bus fault, and the channel stops at once. The data mover itself is outside this block and is seen only as a start pulse, a done strobe and an error flag. The same is true of arbitration between channels.

Top module: `lli_chain_seq`

## Requirements
- R1: After reset all channel registers read zero, busy is low and no request is issued. While busy is low, a write strobe stores the write data in the register picked by the select code: 0 source, 1 destination, 2 next-pointer, 3 control, 4 configuration.
- R2: Writing the configuration register with bit 0 (enable) set while idle raises busy_o and a one-cycle mv_start_o after the edge that takes the write. A configuration write with bit 0 clear starts nothing.
- R3: A descriptor is read as four words at addresses P, P+4, P+8 and P+12, in that order, where P is the next-pointer with its two low bits forced to zero. The words are source, destination, next-pointer and control.
- R4: All four descriptor registers are replaced on the edge that accepts the fourth word, and the next mv_start_o follows in the next cycle with those values on the register outputs.
- R5: A next-pointer whose bits above bit 1 are all zero is null. After that descriptor's mover completes, no read is issued, the enable bit clears and busy_o falls.
- R6: When control bit 31 is set, tc_pulse_o is high for exactly one cycle after the edge that samples a clean mv_done_i. When the bit is clear, no pulse is raised.
- R7: mv_done_i with mv_err_i raises err_pulse_o for one cycle after that edge, with no terminal-count pulse. It also stops the channel and issues no read.
- R8: A read response with mrd_err_i raises err_pulse_o for one cycle after that edge and stops the channel. All four descriptor registers keep the values of the last completed descriptor.
- R9: Configuration bits other than enable are never changed by the sequencing; only the enable bit is cleared when the channel stops.
- R10: Register writes of any select code while busy_o is high are ignored.
- R11: busy_o and the enable bit stay high from the start until the channel stops. Each descriptor gets exactly one mv_start_o, and read requests occur only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_wr_i | input | 1 | Register write strobe |
| sw_sel_i | input | 3 | Register select code |
| sw_wdata_i | input | DW | Register write data |
| src_addr_o | output | AW | Current source address register |
| dst_addr_o | output | AW | Current destination address register |
| next_ptr_o | output | AW | Current next-descriptor pointer register |
| ctrl_o | output | DW | Current control word register |
| cfg_o | output | DW | Configuration register (bit 0 enable) |
| mrd_req_o | output | 1 | Descriptor word read request, held until acknowledged |
| mrd_addr_o | output | AW | Descriptor word byte address |
| mrd_ack_i | input | 1 | Read response strobe |
| mrd_data_i | input | DW | Read response data |
| mrd_err_i | input | 1 | Read response bus fault |
| mv_start_o | output | 1 | One-cycle start for the data mover |
| mv_done_i | input | 1 | Data mover finished the current descriptor |
| mv_err_i | input | 1 | Data mover bus fault, valid with mv_done_i |
| busy_o | output | 1 | Channel active |
| tc_pulse_o | output | 1 | Terminal-count event |
| err_pulse_o | output | 1 | Bus error event |

## Verification
Busy and the first mover start become visible one cycle after the edge that takes the enabling write. A reload is visible one cycle after the edge that takes the fourth descriptor word, and it is seen together with the next start. Terminal-count and error pulses appear exactly one cycle after the edge that samples the done strobe or the faulting read response. The bench drives all inputs on the falling edge and, in the same falling-edge process, records which pulse is due. It then compares the pulse outputs one falling edge later and checks each read address and each mover start at the falling edge where it is presented.

// File: rtl/lli_pkg.sv
package lli_pkg;
   localparam int unsigned DESC_WORDS = 4;
   localparam int unsigned IDX_W      = 2;
   localparam int unsigned W_SRC      = 0;
   localparam int unsigned W_DST      = 1;
   localparam int unsigned W_NEXT     = 2;
   localparam int unsigned W_CTRL     = 3;

   typedef enum logic [2:0] {
      SEL_SRC  = 3'd0,
      SEL_DST  = 3'd1,
      SEL_NEXT = 3'd2,
      SEL_CTRL = 3'd3,
      SEL_CFG  = 3'd4
   } reg_sel_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LAUNCH,
      ST_MOVE,
      ST_FETCH
   } seq_state_e;
endpackage

// File: rtl/lli_fetch_unit.sv
module lli_fetch_unit
   import lli_pkg::*;
#(
   parameter int unsigned AW = 32,
   parameter int unsigned DW = 32
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     go_i,
   input  logic [AW-3:0]            ptr_i,
   input  logic                     ack_i,
   input  logic [DW-1:0]            data_i,
   input  logic                     err_i,
   output logic                     req_o,
   output logic [AW-1:0]            addr_o,
   output logic                     fin_o,
   output logic                     fault_o,
   output logic [DESC_WORDS*DW-1:0] words_o
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

   logic             active_q;
   logic [IDX_W-1:0] idx_q;
   logic [AW-3:0]    base_q;
   logic             take;

   assign take = active_q & ack_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         active_q <= 1'b0;
         idx_q    <= '0;
         base_q   <= '0;
      end else if (go_i) begin
         active_q <= 1'b1;
         idx_q    <= '0;
         base_q   <= ptr_i;
      end else if (take) begin
         if (err_i || (idx_q == LAST_IDX)) begin
            active_q <= 1'b0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign req_o   = active_q;
   assign addr_o  = {base_q, 2'b00} + {{(AW-IDX_W-2){1'b0}}, idx_q, 2'b00};
   assign fault_o = take & err_i;
   assign fin_o   = take & ~err_i & (idx_q == LAST_IDX);

   for (genvar w = 0; w < DESC_WORDS - 1; w++) begin : g_stage
      logic [DW-1:0] stage_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            stage_q <= '0;
         end else if (take && !err_i && (idx_q == IDX_W'(w))) begin
            stage_q <= data_i;
         end
      end
      assign words_o[w*DW +: DW] = stage_q;
   end

   assign words_o[(DESC_WORDS-1)*DW +: DW] = data_i;
endmodule

// File: rtl/lli_seq_ctrl.sv
module lli_seq_ctrl
   import lli_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_set_i,
   input  logic next_null_i,
   input  logic tc_en_i,
   input  logic mv_done_i,
   input  logic mv_err_i,
   input  logic fin_i,
   input  logic fault_i,
   output logic mv_start_o,
   output logic fetch_go_o,
   output logic commit_o,
   output logic stop_o,
   output logic busy_o,
   output logic tc_pulse_o,
   output logic err_pulse_o
);
   seq_state_e state_q, state_d;
   logic       tc_d, err_d, tc_q, err_q;

   always_comb begin
      state_d    = state_q;
      mv_start_o = 1'b0;
      fetch_go_o = 1'b0;
      commit_o   = 1'b0;
      stop_o     = 1'b0;
      tc_d       = 1'b0;
      err_d      = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (en_set_i) state_d = ST_LAUNCH;
         end
         ST_LAUNCH: begin
            mv_start_o = 1'b1;
            state_d    = ST_MOVE;
         end
         ST_MOVE: begin
            if (mv_done_i) begin
               if (mv_err_i) begin
                  err_d   = 1'b1;
                  stop_o  = 1'b1;
                  state_d = ST_IDLE;
               end else begin
                  tc_d = tc_en_i;
                  if (next_null_i) begin
                     stop_o  = 1'b1;
                     state_d = ST_IDLE;
                  end else begin
                     fetch_go_o = 1'b1;
                     state_d    = ST_FETCH;
                  end
               end
            end
         end
         ST_FETCH: begin
            if (fault_i) begin
               err_d   = 1'b1;
               stop_o  = 1'b1;
               state_d = ST_IDLE;
            end else if (fin_i) begin
               commit_o = 1'b1;
               state_d  = ST_LAUNCH;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         tc_q    <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         tc_q    <= tc_d;
         err_q   <= err_d;
      end
   end

   assign busy_o      = (state_q != ST_IDLE);
   assign tc_pulse_o  = tc_q;
   assign err_pulse_o = err_q;
endmodule

// File: rtl/lli_chan_regs.sv
module lli_chan_regs
   import lli_pkg::*;
#(
   parameter int unsigned AW     = 32,
   parameter int unsigned DW     = 32,
   parameter int unsigned EN_BIT = 0
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     sw_wr_i,
   input  logic [2:0]               sw_sel_i,
   input  logic [DW-1:0]            sw_wdata_i,
   input  logic                     busy_i,
   input  logic                     commit_i,
   input  logic [DESC_WORDS*DW-1:0] words_i,
   input  logic                     stop_i,
   output logic [AW-1:0]            src_o,
   output logic [AW-1:0]            dst_o,
   output logic [AW-1:0]            nxt_o,
   output logic [DW-1:0]            ctrl_o,
   output logic [DW-1:0]            cfg_o,
   output logic                     en_set_o
);
   logic          sw_ok;
   logic [AW-1:0] src_q, dst_q, nxt_q;
   logic [DW-1:0] ctrl_q, cfg_q;

   assign sw_ok    = sw_wr_i & ~busy_i;
   assign en_set_o = sw_ok & (sw_sel_i == SEL_CFG) & sw_wdata_i[EN_BIT];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         src_q  <= '0;
         dst_q  <= '0;
         nxt_q  <= '0;
         ctrl_q <= '0;
      end else if (commit_i) begin
         src_q  <= words_i[W_SRC*DW  +: AW];
         dst_q  <= words_i[W_DST*DW  +: AW];
         nxt_q  <= words_i[W_NEXT*DW +: AW];
         ctrl_q <= words_i[W_CTRL*DW +: DW];
      end else if (sw_ok) begin
         case (sw_sel_i)
            SEL_SRC:  src_q  <= sw_wdata_i[AW-1:0];
            SEL_DST:  dst_q  <= sw_wdata_i[AW-1:0];
            SEL_NEXT: nxt_q  <= sw_wdata_i[AW-1:0];
            SEL_CTRL: ctrl_q <= sw_wdata_i;
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q <= '0;
      end else if (stop_i) begin
         cfg_q[EN_BIT] <= 1'b0;
      end else if (sw_ok && (sw_sel_i == SEL_CFG)) begin
         cfg_q <= sw_wdata_i;
      end
   end

   assign src_o  = src_q;
   assign dst_o  = dst_q;
   assign nxt_o  = nxt_q;
   assign ctrl_o = ctrl_q;
   assign cfg_o  = cfg_q;
endmodule

// File: rtl/lli_chain_seq.sv
module lli_chain_seq
   import lli_pkg::*;
#(
   parameter int unsigned AW     = 32,
   parameter int unsigned DW     = 32,
   parameter int unsigned EN_BIT = 0,
   parameter int unsigned TC_BIT = 31
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          sw_wr_i,
   input  logic [2:0]    sw_sel_i,
   input  logic [DW-1:0] sw_wdata_i,
   output logic [AW-1:0] src_addr_o,
   output logic [AW-1:0] dst_addr_o,
   output logic [AW-1:0] next_ptr_o,
   output logic [DW-1:0] ctrl_o,
   output logic [DW-1:0] cfg_o,
   output logic          mrd_req_o,
   output logic [AW-1:0] mrd_addr_o,
   input  logic          mrd_ack_i,
   input  logic [DW-1:0] mrd_data_i,
   input  logic          mrd_err_i,
   output logic          mv_start_o,
   input  logic          mv_done_i,
   input  logic          mv_err_i,
   output logic          busy_o,
   output logic          tc_pulse_o,
   output logic          err_pulse_o
);
   if (AW < 8 || AW > DW) begin : g_bad_aw
      $error("lli_chain_seq: AW must lie between 8 and DW");
   end
   if (EN_BIT >= DW) begin : g_bad_en
      $error("lli_chain_seq: EN_BIT outside configuration word");
   end
   if (TC_BIT >= DW) begin : g_bad_tc
      $error("lli_chain_seq: TC_BIT outside control word");
   end

   logic                     en_set, next_null, fetch_go, commit, stop;
   logic                     fin, fault;
   logic [DESC_WORDS*DW-1:0] words;

   assign next_null = (next_ptr_o[AW-1:2] == '0);

   lli_chan_regs #(.AW(AW), .DW(DW), .EN_BIT(EN_BIT)) regs_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sw_wr_i    (sw_wr_i),
      .sw_sel_i   (sw_sel_i),
      .sw_wdata_i (sw_wdata_i),
      .busy_i     (busy_o),
      .commit_i   (commit),
      .words_i    (words),
      .stop_i     (stop),
      .src_o      (src_addr_o),
      .dst_o      (dst_addr_o),
      .nxt_o      (next_ptr_o),
      .ctrl_o     (ctrl_o),
      .cfg_o      (cfg_o),
      .en_set_o   (en_set)
   );

   lli_seq_ctrl ctrl_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_set_i    (en_set),
      .next_null_i (next_null),
      .tc_en_i     (ctrl_o[TC_BIT]),
      .mv_done_i   (mv_done_i),
      .mv_err_i    (mv_err_i),
      .fin_i       (fin),
      .fault_i     (fault),
      .mv_start_o  (mv_start_o),
      .fetch_go_o  (fetch_go),
      .commit_o    (commit),
      .stop_o      (stop),
      .busy_o      (busy_o),
      .tc_pulse_o  (tc_pulse_o),
      .err_pulse_o (err_pulse_o)
   );

   lli_fetch_unit #(.AW(AW), .DW(DW)) fetch_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .go_i    (fetch_go),
      .ptr_i   (next_ptr_o[AW-1:2]),
      .ack_i   (mrd_ack_i),
      .data_i  (mrd_data_i),
      .err_i   (mrd_err_i),
      .req_o   (mrd_req_o),
      .addr_o  (mrd_addr_o),
      .fin_o   (fin),
      .fault_o (fault),
      .words_o (words)
   );
endmodule

// File: rtl/lli_chain_seq_chk.sv
module lli_chain_seq_chk #(
   parameter int unsigned AW     = 32,
   parameter int unsigned DW     = 32,
   parameter int unsigned EN_BIT = 0,
   parameter int unsigned TC_BIT = 31
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic [AW-1:0] src_addr_o,
   input logic [AW-1:0] dst_addr_o,
   input logic [DW-1:0] ctrl_o,
   input logic [DW-1:0] cfg_o,
   input logic          mrd_req_o,
   input logic [AW-1:0] mrd_addr_o,
   input logic          mrd_ack_i,
   input logic          mv_start_o,
   input logic          mv_done_i,
   input logic          mv_err_i,
   input logic          busy_o,
   input logic          tc_pulse_o,
   input logic          err_pulse_o
);
   localparam logic [DW-1:0] EN_MASK = {{(DW-1){1'b0}}, 1'b1} << EN_BIT;

   AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mv_start_o |=> !mv_start_o); // R11
   AST_START_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mv_start_o |-> (busy_o && cfg_o[EN_BIT])); // R2
   AST_REQ_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mrd_req_o |-> (mrd_addr_o[1:0] == 2'b00)); // R3
   AST_REQ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mrd_req_o |-> (busy_o && !mv_start_o)); // R11
   AST_TC_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tc_pulse_o |-> ($past(mv_done_i) && !$past(mv_err_i) && $past(ctrl_o[TC_BIT]))); // R6
   AST_NO_TC_WITH_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(tc_pulse_o && err_pulse_o)); // R7
   AST_ERR_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_pulse_o |-> (!busy_o && !cfg_o[EN_BIT])); // R8
   AST_ENABLE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> cfg_o[EN_BIT]); // R11
   AST_CFG_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && $past(busy_o)) |-> ((cfg_o & ~EN_MASK) == ($past(cfg_o) & ~EN_MASK))); // R9
   AST_REGS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && $past(busy_o) && !$past(mrd_ack_i)) |-> ($stable(src_addr_o) && $stable(dst_addr_o))); // R10
endmodule

bind lli_chain_seq lli_chain_seq_chk #(
   .AW(AW), .DW(DW), .EN_BIT(EN_BIT), .TC_BIT(TC_BIT)
) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .src_addr_o  (src_addr_o),
   .dst_addr_o  (dst_addr_o),
   .ctrl_o      (ctrl_o),
   .cfg_o       (cfg_o),
   .mrd_req_o   (mrd_req_o),
   .mrd_addr_o  (mrd_addr_o),
   .mrd_ack_i   (mrd_ack_i),
   .mv_start_o  (mv_start_o),
   .mv_done_i   (mv_done_i),
   .mv_err_i    (mv_err_i),
   .busy_o      (busy_o),
   .tc_pulse_o  (tc_pulse_o),
   .err_pulse_o (err_pulse_o)
);

// File: tb/lli_chain_seq_tb.sv
module lli_chain_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_wr = 1'b0;
   logic [2:0]  sw_sel = 3'd0;
   logic [31:0] sw_wdata = 32'd0;
   logic [31:0] src_addr_o, dst_addr_o, next_ptr_o, ctrl_o, cfg_o, mrd_addr_o;
   logic        mrd_req_o, mv_start_o, busy_o, tc_pulse_o, err_pulse_o;
   logic        mrd_ack = 1'b0, mrd_err = 1'b0, mv_done = 1'b0, mv_err = 1'b0;
   logic [31:0] mrd_data = 32'd0;

   always #2 clk = ~clk;

   lli_chain_seq dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .sw_wr_i(sw_wr), .sw_sel_i(sw_sel), .sw_wdata_i(sw_wdata),
      .src_addr_o(src_addr_o), .dst_addr_o(dst_addr_o), .next_ptr_o(next_ptr_o),
      .ctrl_o(ctrl_o), .cfg_o(cfg_o),
      .mrd_req_o(mrd_req_o), .mrd_addr_o(mrd_addr_o), .mrd_ack_i(mrd_ack),
      .mrd_data_i(mrd_data), .mrd_err_i(mrd_err),
      .mv_start_o(mv_start_o), .mv_done_i(mv_done), .mv_err_i(mv_err),
      .busy_o(busy_o), .tc_pulse_o(tc_pulse_o), .err_pulse_o(err_pulse_o)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // scenario settings
   int L = 1, mis = 0, mem_lat = 0, mv_lat = 0, ferr_d = 99, ferr_w = 0, merr_d = 99;
   logic [3:0] tcmask = 4'd0;
   logic [31:0] mem [0:255];

   function automatic logic [31:0] f_src(int i);  return 32'h1000_0000 + 32'(i) * 32'h100; endfunction
   function automatic logic [31:0] f_dst(int i);  return 32'h2000_0000 + 32'(i) * 32'h44;  endfunction
   function automatic logic [31:0] f_base(int j); return 32'h100 + 32'(j) * 32'h40;        endfunction
   function automatic logic [31:0] f_next(int i);
      return (i < L - 1) ? (f_base(i + 1) | 32'(mis)) : 32'(mis);
   endfunction
   function automatic logic [31:0] f_ctrl(int i); return {tcmask[i], 31'(i * 3 + 5)}; endfunction

   // monitor, mover model and memory model
   int starts = 0, cur = 0, wcnt = 0, lat_cnt = 0, mv_cnt = 0, tc_seen = 0, err_seen = 0;
   bit tc_due = 1'b0, err_due = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (tc_pulse_o || tc_due) chk(tc_pulse_o == tc_due, "R6 tc pulse timing", 32'(tc_pulse_o), 32'(tc_due));
         if (err_pulse_o || err_due) chk(err_pulse_o == err_due, "R7 error pulse timing", 32'(err_pulse_o), 32'(err_due));
         if (tc_pulse_o) tc_seen++;
         if (err_pulse_o) err_seen++;
         tc_due = 1'b0;
         err_due = 1'b0;
         mv_done = 1'b0;
         mv_err = 1'b0;
         if (mv_cnt > 0) begin
            mv_cnt--;
            if (mv_cnt == 0) begin
               mv_done = 1'b1;
               mv_err = (cur == merr_d);
               err_due = mv_err;
               tc_due = !mv_err && tcmask[cur];
            end
         end
         if (mv_start_o) begin
            chk(src_addr_o == f_src(starts), "R4 source at start", src_addr_o, f_src(starts));
            chk(dst_addr_o == f_dst(starts), "R4 destination at start", dst_addr_o, f_dst(starts));
            chk(ctrl_o == f_ctrl(starts), "R4 control at start", ctrl_o, f_ctrl(starts));
            cur = starts;
            starts++;
            wcnt = 0;
            mv_cnt = mv_lat + 1;
         end
         mrd_ack = 1'b0;
         mrd_err = 1'b0;
         if (mrd_req_o) begin
            if (lat_cnt >= mem_lat) begin
               chk(mrd_addr_o == f_base(starts) + 32'(4 * wcnt), "R3 fetch address", mrd_addr_o,
                   f_base(starts) + 32'(4 * wcnt));
               mrd_ack = 1'b1;
               mrd_data = mem[mrd_addr_o[9:2]];
               mrd_err = (starts == ferr_d) && (wcnt == ferr_w);
               if (mrd_err) err_due = 1'b1;
               wcnt++;
               lat_cnt = 0;
            end else begin
               lat_cnt++;
            end
         end else begin
            lat_cnt = 0;
         end
      end
   end

   task automatic sw_write(input logic [2:0] sel, input logic [31:0] v);
      @(negedge clk);
      sw_wr = 1'b1;
      sw_sel = sel;
      sw_wdata = v;
      @(negedge clk);
      sw_wr = 1'b0;
   endtask

   task automatic run(input int l, input logic [3:0] m, input int ml, input int vl,
                      input int fd, input int fw, input int md, input bit poke);
      int exp_starts, exp_last, exp_tc, exp_err;
      logic [31:0] cfgpat;
      L = l; tcmask = m; mis = (l + int'(m)) % 4; mem_lat = ml; mv_lat = vl;
      ferr_d = fd; ferr_w = fw; merr_d = md;
      cfgpat = 32'h5AC3_00F0 ^ (32'(l) << 8);
      for (int j = 1; j < L; j++) begin
         mem[(f_base(j) >> 2) + 0] = f_src(j);
         mem[(f_base(j) >> 2) + 1] = f_dst(j);
         mem[(f_base(j) >> 2) + 2] = f_next(j);
         mem[(f_base(j) >> 2) + 3] = f_ctrl(j);
      end
      exp_starts = 0; exp_last = 0; exp_tc = 0; exp_err = 0;
      for (int i = 0; i < L; i++) begin
         exp_starts++;
         exp_last = i;
         if (i == merr_d) begin exp_err = 1; break; end
         if (tcmask[i]) exp_tc++;
         if (i == L - 1) break;
         if (i + 1 == ferr_d) begin exp_err = 1; break; end
      end
      starts = 0; tc_seen = 0; err_seen = 0;
      sw_write(3'd0, f_src(0));
      sw_write(3'd1, f_dst(0));
      sw_write(3'd2, f_next(0));
      sw_write(3'd3, f_ctrl(0));
      sw_write(3'd4, cfgpat | 32'd1);
      chk(busy_o == 1'b1, "R2 busy after enable", 32'(busy_o), 32'd1);
      if (poke) begin
         sw_write(3'd0, 32'hDEAD_BEEF);
         sw_write(3'd4, 32'h0000_0000);
         chk(busy_o == 1'b1 && cfg_o[0], "R10 enable kept after busy write", cfg_o, cfgpat | 32'd1);
      end
      for (int c = 0; c < 3000 && busy_o; c++) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(starts == exp_starts, "R11 mover starts", 32'(starts), 32'(exp_starts));
      chk(tc_seen == exp_tc, "R6 terminal count events", 32'(tc_seen), 32'(exp_tc));
      chk(err_seen == exp_err, "R7 error events", 32'(err_seen), 32'(exp_err));
      chk(src_addr_o == f_src(exp_last), fd < 99 ? "R8 source kept" : "R4 final source", src_addr_o, f_src(exp_last));
      chk(dst_addr_o == f_dst(exp_last), fd < 99 ? "R8 destination kept" : "R4 final destination", dst_addr_o, f_dst(exp_last));
      chk(next_ptr_o == f_next(exp_last), fd < 99 ? "R8 pointer kept" : "R4 final pointer", next_ptr_o, f_next(exp_last));
      chk(ctrl_o == f_ctrl(exp_last), fd < 99 ? "R8 control kept" : "R4 final control", ctrl_o, f_ctrl(exp_last));
      chk(cfg_o == cfgpat, "R9 configuration kept, enable cleared", cfg_o, cfgpat);
      chk(busy_o == 1'b0 && !mrd_req_o, "R5 stopped", 32'(busy_o), 32'd0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_o == 1'b0, "R1 reset busy", 32'(busy_o), 32'd0);
      chk(src_addr_o == 32'd0 && dst_addr_o == 32'd0, "R1 reset addresses", src_addr_o, 32'd0);
      chk(cfg_o == 32'd0 && ctrl_o == 32'd0 && next_ptr_o == 32'd0, "R1 reset registers", cfg_o, 32'd0);
      chk(!mrd_req_o && !mv_start_o, "R1 reset requests", 32'(mrd_req_o), 32'd0);
      sw_write(3'd1, 32'h0BAD_F00D);
      chk(dst_addr_o == 32'h0BAD_F00D, "R1 idle write readback", dst_addr_o, 32'h0BAD_F00D);
      sw_write(3'd4, 32'h0000_00F0);
      repeat (4) @(negedge clk);
      chk(cfg_o == 32'h0000_00F0, "R1 configuration write", cfg_o, 32'h0000_00F0);
      chk(starts == 0 && !busy_o, "R2 no start without enable", 32'(starts), 32'd0);
      // chain sweep: length 1..3, every terminal-count pattern, varied latencies and misalignment
      for (int l = 1; l <= 3; l++) begin
         for (int m = 0; m < (1 << l); m++) begin
            run(l, 4'(m), m % 3, (l + m) % 3, 99, 0, 99, 1'b0);
         end
      end
      // mover faults on each descriptor
      for (int d = 0; d < 3; d++) run(3, 4'b0111, 1, 1, 99, 0, d, 1'b0);
      // fetch faults on each word of each fetched descriptor
      for (int d = 1; d < 3; d++) begin
         for (int w = 0; w < 4; w++) run(3, 4'b0101, w % 2, 0, d, w, 99, 1'b0);
      end
      // writes while busy
      run(2, 4'b0011, 1, 3, 99, 0, 99, 1'b1);
      run(1, 4'b0001, 0, 4, 99, 0, 99, 1'b1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule